// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block drives the external reset or alert line that a watchdog raises when it expires. A one-cycle trigger starts a pulse whose length is counted in microsecond ticks. A single 32-bit configuration word sets three things: the pulse length, the asserted polarity of the line, and whether the pad is driven push-pull or emulated open-drain.

The low field of the word holds the pulse length and takes effect on every write. Polarity and drive mode are protected. Each changes only when one of four key values is written to the top byte of the word. Any other top byte leaves both unchanged, but the length field of the same write is still stored.

The pad is described by a data bit and an output-enable bit. Together they produce either a driven line or a line that is only ever pulled low. The microsecond tick comes from a shared timebase outside the block.

Top module: `xrst_pulse_gen`

## Requirements
- R1: After reset, the read word is 0x000000FF: length 255, active-low (bit 31 = 0), open-drain (bit 30 = 0). The pad is idle with `pad_o`=0 and `pad_oe`=0.
- R2: Every write stores `wr_data[19:0]` as the length field. Read bits 29:20 always return 0.
- R3: A write with top byte 0xA5 sets bit 31 to 1 (active-high). A write with top byte 0x5A clears bit 31 to 0 (active-low).
- R4: A write with top byte 0xA8 sets bit 30 to 1 (push-pull). A write with top byte 0x8A clears bit 30 to 0 (open-drain).
- R5: A write with any other top byte leaves bits 31 and 30 unchanged.
- R6: A trigger asserts the line from the next cycle on. With length field N, the line stays asserted until the edge that samples the (N+1)th tick after the trigger, and is idle from that edge on.
- R7: A trigger during an active pulse reloads the count from the current length field. A trigger and a tick in the same cycle act as a trigger alone.
- R8: In push-pull mode, `pad_oe` is 1. `pad_o` equals the line level: 1 when asserted and active-high, or when idle and active-low; otherwise 0.
- R9: In open-drain mode, `pad_o` is 0. `pad_oe` is 1 exactly when the line level is low.
- R10: Ticks while no pulse is active leave the line idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Current configuration word |
| tick_1us | input | 1 | One-cycle microsecond tick enable |
| fire | input | 1 | One-cycle pulse trigger |
| pad_o | output | 1 | Pad data |
| pad_oe | output | 1 | Pad output enable |

## Verification
The assertions check, on every cycle, several rules: the length field is captured on each write, the key values set polarity and drive mode, non-key top bytes hold those modes, a trigger asserts the line and loads the count, and idle ticks do nothing. Only the bench scenarios can show the pulse length of N+1 ticks, the restart behaviour, and the pad data and enable encoding in all four mode combinations. The bench sweeps every top-byte value and several short lengths.

// File: rtl/xrst_pkg.sv
package xrst_pkg;

    parameter int unsigned XR_WORD_W = 32;
    parameter int unsigned XR_DUR_W  = 20;
    localparam int unsigned XR_PAD_W = XR_WORD_W - 2 - XR_DUR_W;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} xr_pol_e;
    typedef enum logic {DRV_OD = 1'b0, DRV_PP = 1'b1} xr_drv_e;

    typedef struct packed {
        xr_pol_e               pol;
        xr_drv_e               drv;
        logic [XR_DUR_W-1:0]   dur;
    } xr_cfg_t;

    function automatic logic [XR_WORD_W-1:0] cfg_to_word(xr_cfg_t c);
        return {c.pol, c.drv, {XR_PAD_W{1'b0}}, c.dur};
    endfunction

    function automatic logic line_level(xr_pol_e p, logic asserted);
        return (p == POL_HIGH) ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/xrst_cfg_reg.sv
module xrst_cfg_reg
    import xrst_pkg::*;
#(
    parameter logic [XR_DUR_W-1:0] DUR_RESET = 'hFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [XR_WORD_W-1:0] wr_data,
    output xr_cfg_t              cfg
);
    localparam int unsigned TOP_LSB = XR_WORD_W - 8;

    xr_cfg_t    cfg_q, cfg_d;
    logic [7:0] top_byte;

    assign top_byte = wr_data[XR_WORD_W-1:TOP_LSB];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.dur = wr_data[XR_DUR_W-1:0];
            case (top_byte)
                KEY_POL_HIGH: cfg_d.pol = POL_HIGH;
                KEY_POL_LOW:  cfg_d.pol = POL_LOW;
                KEY_DRV_PP:   cfg_d.drv = DRV_PP;
                KEY_DRV_OD:   cfg_d.drv = DRV_OD;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.pol <= POL_LOW;
            cfg_q.drv <= DRV_OD;
            cfg_q.dur <= DUR_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    AST_DUR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cfg_q.dur == $past(wr_data[XR_DUR_W-1:0])); // R2
    AST_KEY_POL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && top_byte == KEY_POL_HIGH) |=> cfg_q.pol == POL_HIGH); // R3
    AST_KEY_POL_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && top_byte == KEY_POL_LOW) |=> cfg_q.pol == POL_LOW); // R3
    AST_KEY_DRV_PP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && top_byte == KEY_DRV_PP) |=> cfg_q.drv == DRV_PP); // R4
    AST_KEY_DRV_OD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && top_byte == KEY_DRV_OD) |=> cfg_q.drv == DRV_OD); // R4
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (top_byte != KEY_POL_HIGH && top_byte != KEY_POL_LOW) |=> $stable(cfg_q.pol)); // R5
    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (top_byte != KEY_DRV_PP && top_byte != KEY_DRV_OD) |=> $stable(cfg_q.drv)); // R5

endmodule

// File: rtl/xrst_pulse_timer.sv
module xrst_pulse_timer
    import xrst_pkg::*;
#(
    parameter int unsigned CNT_W = XR_DUR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             active
);
    logic [CNT_W-1:0] cnt_q;
    logic             act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (fire) begin
            cnt_q <= load_val;
            act_q <= 1'b1;
        end else if (act_q && tick) begin
            if (cnt_q == '0) begin
                act_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign active = act_q;

    AST_FIRE_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        fire |=> act_q); // R6
    AST_FIRE_LOADS: assert property (@(posedge clk) disable iff (rst)
        fire |=> cnt_q == $past(load_val)); // R7
    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
        (!act_q && !fire) |=> !act_q); // R10
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act_q && !fire && !tick) |=> (act_q && $stable(cnt_q))); // R6

endmodule

// File: rtl/xrst_pad_drv.sv
module xrst_pad_drv
    import xrst_pkg::*;
(
    input  logic    active,
    input  xr_pol_e pol,
    input  xr_drv_e drv,
    output logic    pad_o,
    output logic    pad_oe
);
    logic level;

    assign level = line_level(pol, active);

    always_comb begin
        if (drv == DRV_PP) begin
            pad_o  = level;
            pad_oe = 1'b1;
        end else begin
            pad_o  = 1'b0;
            pad_oe = ~level;
        end
    end

endmodule

// File: rtl/xrst_pulse_gen.sv
module xrst_pulse_gen
    import xrst_pkg::*;
#(
    parameter logic [XR_DUR_W-1:0] DUR_RESET = 'hFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [XR_WORD_W-1:0] wr_data,
    output logic [XR_WORD_W-1:0] rd_data,
    input  logic                 tick_1us,
    input  logic                 fire,
    output logic                 pad_o,
    output logic                 pad_oe
);
    xr_cfg_t cfg;
    logic    active;

    xrst_cfg_reg #(.DUR_RESET(DUR_RESET)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    xrst_pulse_timer #(.CNT_W(XR_DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .tick     (tick_1us),
        .load_val (cfg.dur),
        .active   (active)
    );

    xrst_pad_drv u_pad (
        .active (active),
        .pol    (cfg.pol),
        .drv    (cfg.drv),
        .pad_o  (pad_o),
        .pad_oe (pad_oe)
    );

    assign rd_data = cfg_to_word(cfg);

    AST_RESET_WORD: assert property (@(posedge clk)
        rst |=> rd_data == {{(XR_WORD_W-XR_DUR_W){1'b0}}, DUR_RESET}); // R1

endmodule

// File: tb/test_xrst_pulse_gen.sv
`timescale 1ns/1ps
module test_xrst_pulse_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_1us = 1'b0;
    logic        fire = 1'b0;
    logic        pad_o, pad_oe;

    int n_run = 0;
    int n_fail = 0;

    logic        m_pol = 1'b0;
    logic        m_drv = 1'b0;
    logic [19:0] m_dur = 20'hFF;

    always #2.5 clk = ~clk;

    xrst_pulse_gen i_xrst_pulse_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tick_1us(tick_1us), .fire(fire), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_pad(input logic asserted, input string ctx);
        logic lvl, e_o, e_oe;
        string tag;
        lvl  = m_pol ? asserted : ~asserted;
        e_o  = m_drv ? lvl : 1'b0;
        e_oe = m_drv ? 1'b1 : ~lvl;
        tag  = m_drv ? {ctx, " R8"} : {ctx, " R9"};
        chk(pad_o == e_o && pad_oe == e_oe, tag, {30'b0, pad_o, pad_oe}, {30'b0, e_o, e_oe});
    endtask

    task automatic wr(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        step();
        wr_en = 1'b0;
        m_dur = w[19:0];
        case (w[31:24])
            8'hA5: m_pol = 1'b1;
            8'h5A: m_pol = 1'b0;
            8'hA8: m_drv = 1'b1;
            8'h8A: m_drv = 1'b0;
            default: ;
        endcase
    endtask

    task automatic run_pulse(input logic [19:0] n, input logic [7:0] pk, input logic [7:0] dk);
        int ticks;
        logic exp_a;
        wr({pk, 4'h0, n});
        wr({dk, 4'h0, n});
        fire = 1'b1;
        step();
        fire = 1'b0;
        chk_pad(1'b1, "R6 assert");
        ticks = 0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            tick_1us = cyc[0];
            step();
            if (tick_1us) ticks++;
            tick_1us = 1'b0;
            exp_a = (ticks <= int'(n));
            chk_pad(exp_a, "R6 pulse");
            if (!exp_a) break;
        end
        chk(ticks == int'(n) + 1, "R6 length", ticks, int'(n) + 1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int ticks;
        logic [7:0] keys_p [2];
        logic [7:0] keys_d [2];
        keys_p[0] = 8'h5A; keys_p[1] = 8'hA5;
        keys_d[0] = 8'h8A; keys_d[1] = 8'hA8;

        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(rd_data == 32'h0000_00FF, "R1 word", rd_data, 32'h0000_00FF);
        chk(pad_o == 1'b0 && pad_oe == 1'b0, "R1 pad", {pad_o, pad_oe}, 0);

        // R10 idle ticks
        for (int i = 0; i < 6; i++) begin
            tick_1us = 1'b1;
            step();
        end
        tick_1us = 1'b0;
        chk_pad(1'b0, "R10 idle");

        // Sweep of every top byte, R2 R3 R4 R5
        for (int k = 0; k < 256; k++) begin
            logic [31:0] w, e;
            string tag;
            w = {k[7:0], 4'hF, 20'(k * 4099 + 7)};
            wr(w);
            e = {m_pol, m_drv, 10'b0, m_dur};
            if (k == 8'hA5 || k == 8'h5A) tag = "R3 key";
            else if (k == 8'hA8 || k == 8'h8A) tag = "R4 key";
            else tag = "R5 nonkey";
            chk(rd_data == e, tag, rd_data, e);
            chk(rd_data[29:0] == {10'b0, w[19:0]}, "R2 field", rd_data, {12'b0, w[19:0]});
            chk_pad(1'b0, "idle");
        end

        // Pulse lengths over all modes, R6 R8 R9
        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 2; d++)
                for (int n = 0; n < 5; n++)
                    run_pulse(20'(n), keys_p[p], keys_d[d]);

        // R7 restart, with tick coinciding with trigger
        wr({8'hA5, 4'h0, 20'd5});
        wr({8'hA8, 4'h0, 20'd5});
        fire = 1'b1;
        step();
        fire = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick_1us = 1'b1;
            step();
        end
        chk_pad(1'b1, "R7 mid");
        fire = 1'b1;
        tick_1us = 1'b1;
        step();
        fire = 1'b0;
        ticks = 0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            step();
            ticks++;
            if (!(pad_o == 1'b1)) break;
        end
        tick_1us = 1'b0;
        chk(ticks == 6, "R7 restart length", ticks, 6);
        chk_pad(1'b0, "R7 end");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule